// File: doc/BRIEF.md
# Grayscale Passive-Matrix LCD Timing Controller

This block drives a passive grayscale LCD panel from a packed frame buffer held in word-addressed memory. A single 32-bit control word sets the frame buffer size, the line length, the pixel clock divider, the AC-bias period and the pixel depth (1, 2 or 4 bits). While the controller is enabled it walks the buffer word by word. It unpacks pixels starting at the least significant bits and maps each pixel to a 4-bit gray level. Alongside the pixel stream it produces the pixel strobe, the line pulse, the first-line frame marker and the alternating AC-bias signal.

Software loads the control word and the two palette words while the controller is disabled, then raises the enable. The control word is frozen while the enable is high. The palette may be rewritten at any time and affects the next pixel shown. Memory reads are combinational: the block presents a word address, and the word on `memData` is used in the same cycle.

Top module: `stn_gray_lcd`

## Requirements
- R1: The control word is laid out as follows. Bits [12:0] give the frame size as (frame bits / 128) − 1. Bits [18:13] give the line length as (pixels per line / 16) − 1. Bits [24:19] give the pixel divider. Bits [29:25] give the AC-bias divider. Bit 30 is the gray enable and bit 31 is the deep-gray select. The word is loaded on a `cfgWrEn` cycle while `ctrlEn` is low.
- R2: While enabled, `pixClk` is a one-cycle pulse that repeats every (pixel divider + 1) clocks. The first pulse follows the (divider + 1)-th enabled edge by one register.
- R3: After reset, and one clock after `ctrlEn` goes low, `pixClk`, `lineClk`, `frameMark`, `acBias` and `grayOut` are 0, and `memAddr` is 0.
- R4: The depth is 4 bpp when bits 31 and 30 are both set, 2 bpp when only bit 30 is set, and 1 bpp otherwise (this includes the case where only bit 31 is set).
- R5: Pixels are taken from each 32-bit word starting at bit 0, at the selected depth. `memAddr` holds the word of the next pixel and advances after the last pixel in that word.
- R6: In 1 bpp mode, a pixel bit of 1 gives `grayOut` = 15 and a bit of 0 gives 0. The palette is not used.
- R7: In 2 bpp and 4 bpp modes, `grayOut` is palette entry n. Entries 0–7 are held in the low palette word and entries 8–15 in the high word. Entry n sits at bits [4·(n mod 8)+3 : 4·(n mod 8)]. A palette write changes the next pixel shown.
- R8: `lineClk` pulses together with the `pixClk` of the last pixel of each line. A line has (line field + 1) × 16 pixels.
- R9: After (frame field + 1) × 128 bits the frame ends. The last pixel also ends the line, and the next pixel is read from word 0 again.
- R10: `frameMark` is high for the pixels of the first line of each frame and low for the pixels of the other lines.
- R11: `acBias` toggles in the same cycle as every (AC divider + 1)-th `lineClk` pulse, and at no other time.
- R12: A `cfgWrEn` while `ctrlEn` is high has no effect on the pixel rate, the depth or the geometry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlEn | input | 1 | Controller enable |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word value |
| palWrEn | input | 1 | Palette word write strobe |
| palWrHigh | input | 1 | 0 selects entries 0–7, 1 selects entries 8–15 |
| palWrData | input | 32 | Palette word value |
| memAddr | output | 15 | Frame buffer word address |
| memData | input | 32 | Frame buffer word read at memAddr |
| pixClk | output | 1 | Pixel strobe |
| lineClk | output | 1 | Line pulse (CL1) |
| frameMark | output | 1 | First-line frame marker |
| acBias | output | 1 | AC-bias (M) signal |
| grayOut | output | 4 | Gray level of the current pixel |

## Verification
The end of a line and the AC-bias toggle can land on the same pixel strobe. The end of a frame and the end of a line can also coincide. When the frame ends part way through a line, the short last line must still produce CL1 and still count toward the AC-bias group. The tests set the AC divider so that the line count per frame is not a multiple of the group size. They also include a 1 bpp geometry in which the frame holds 2⅔ lines. A behavioural model derives every output from the global pixel number and is compared on every clock, so a toggle, a marker or an address wrap that comes one pixel late or early shows up as a mismatch.

// File: rtl/stn_lcd_pkg.sv
package stn_lcd_pkg;
  localparam int WORD_W    = 32;
  localparam int FRAME_W   = 13;
  localparam int LINE_F_W  = 6;
  localparam int DIV_W     = 6;
  localparam int AC_W      = 5;
  localparam int UNIT_BITS = 128;
  localparam int LINE_UNIT = 16;
  localparam int UNIT_SH   = $clog2(UNIT_BITS / WORD_W);
  localparam int ADDR_W    = FRAME_W + UNIT_SH;
  localparam int LINE_W    = LINE_F_W + $clog2(LINE_UNIT);
  localparam int BIT_IDX_W = $clog2(WORD_W);
  localparam int LEVEL_W   = 4;

  typedef struct packed {
    logic                deepEn;
    logic                grayEn;
    logic [AC_W-1:0]     acPre;
    logic [DIV_W-1:0]    pixPre;
    logic [LINE_F_W-1:0] lineLen;
    logic [FRAME_W-1:0]  frameSize;
  } lcdCfg_t;

  typedef struct packed {
    logic                 running;
    logic                 pixTick;
    logic                 lineEnd;
    logic                 acFlip;
    logic                 firstLine;
    logic [1:0]           bppLog;
    logic [BIT_IDX_W-1:0] bitOff;
  } lcdStrobe_t;
endpackage

// File: rtl/stnTimingCtrl.sv
module stnTimingCtrl
  import stn_lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlEn,
  input  logic              cfgWrEn,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [ADDR_W-1:0] memAddr,
  output lcdStrobe_t        strb
);
  lcdCfg_t cfgReg;
  logic [DIV_W-1:0]     divCnt;
  logic [BIT_IDX_W-1:0] pixInWord;
  logic [ADDR_W-1:0]    wordIdx;
  logic [LINE_W-1:0]    pixInLine;
  logic [AC_W-1:0]      acCnt;
  logic                 firstLine;

  logic [1:0]           bppLog;
  logic [BIT_IDX_W-1:0] lastPixInWord;
  logic [ADDR_W-1:0]    lastWord;
  logic [LINE_W-1:0]    lineLast;
  logic pixTick, wordEnd, frameEnd, lineEnd, acFlip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (cfgWrEn && !ctrlEn) cfgReg <= lcdCfg_t'(cfgWrData);
  end

  always_comb begin
    if (cfgReg.grayEn && cfgReg.deepEn) bppLog = 2'd2;
    else if (cfgReg.grayEn)             bppLog = 2'd1;
    else                                bppLog = 2'd0;
    lastPixInWord = BIT_IDX_W'(WORD_W - 1) >> bppLog;
    lastWord      = {cfgReg.frameSize, {UNIT_SH{1'b1}}};
    lineLast      = {cfgReg.lineLen, {($clog2(LINE_UNIT)){1'b1}}};
    pixTick  = ctrlEn && (divCnt == cfgReg.pixPre);
    wordEnd  = (pixInWord == lastPixInWord);
    frameEnd = wordEnd && (wordIdx == lastWord);
    lineEnd  = (pixInLine == lineLast) || frameEnd;
    acFlip   = pixTick && lineEnd && (acCnt == cfgReg.acPre);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; pixInWord <= '0; wordIdx <= '0;
      pixInLine <= '0; acCnt <= '0; firstLine <= 1'b1;
    end else if (!ctrlEn) begin
      divCnt <= '0; pixInWord <= '0; wordIdx <= '0;
      pixInLine <= '0; acCnt <= '0; firstLine <= 1'b1;
    end else if (pixTick) begin
      divCnt    <= '0;
      pixInWord <= wordEnd ? '0 : pixInWord + 1'b1;
      if (frameEnd)     wordIdx <= '0;
      else if (wordEnd) wordIdx <= wordIdx + 1'b1;
      pixInLine <= lineEnd ? '0 : pixInLine + 1'b1;
      if (frameEnd)     firstLine <= 1'b1;
      else if (lineEnd) firstLine <= 1'b0;
      if (lineEnd)      acCnt <= acFlip ? '0 : acCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign memAddr = wordIdx;

  always_comb begin
    strb.running   = ctrlEn;
    strb.pixTick   = pixTick;
    strb.lineEnd   = lineEnd;
    strb.acFlip    = acFlip;
    strb.firstLine = firstLine;
    strb.bppLog    = bppLog;
    strb.bitOff    = pixInWord << bppLog;
  end

  // R12: control word frozen while running
  assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && cfgWrEn) |=> $stable(cfgReg));
  // R9: word address never leaves the frame
  assert_word_in_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEn |-> (wordIdx <= lastWord));
  // R2: divider stays within its period
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlEn |-> (divCnt <= cfgReg.pixPre));
endmodule

// File: rtl/stnPixelPath.sv
module stnPixelPath
  import stn_lcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               palWrEn,
  input  logic               palWrHigh,
  input  logic [WORD_W-1:0]  palWrData,
  input  logic [WORD_W-1:0]  memData,
  input  lcdStrobe_t         strb,
  output logic               pixClk,
  output logic               lineClk,
  output logic               frameMark,
  output logic               acBias,
  output logic [LEVEL_W-1:0] grayOut
);
  logic [WORD_W-1:0]  palBank [2];
  logic [WORD_W-1:0]  shifted;
  logic [3:0]         palIdx;
  logic [LEVEL_W-1:0] level;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) palBank[b] <= '0;
      else if (palWrEn && (palWrHigh == 1'(b))) palBank[b] <= palWrData;
    end
  end

  always_comb begin
    shifted = memData >> strb.bitOff;
    case (strb.bppLog)
      2'd0:    palIdx = {3'b000, shifted[0]};
      2'd1:    palIdx = {2'b00, shifted[1:0]};
      default: palIdx = shifted[3:0];
    endcase
    if (strb.bppLog == 2'd0) level = {LEVEL_W{shifted[0]}};
    else level = palBank[palIdx[3]][{palIdx[2:0], 2'b00} +: LEVEL_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixClk <= 1'b0; lineClk <= 1'b0; frameMark <= 1'b0; acBias <= 1'b0; grayOut <= '0;
    end else if (!strb.running) begin
      pixClk <= 1'b0; lineClk <= 1'b0; frameMark <= 1'b0; acBias <= 1'b0; grayOut <= '0;
    end else if (strb.pixTick) begin
      pixClk    <= 1'b1;
      lineClk   <= strb.lineEnd;
      frameMark <= strb.firstLine;
      acBias    <= acBias ^ strb.acFlip;
      grayOut   <= level;
    end else begin
      pixClk  <= 1'b0;
      lineClk <= 1'b0;
    end
  end

  // R8: a line pulse always rides on a pixel strobe
  assert_cl1_on_pixel_R8: assert property (@(posedge clk) disable iff (!rstN)
    lineClk |-> pixClk);
  // R11: bias moves only together with a line pulse
  assert_bias_on_cl1_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.running && acBias != $past(acBias)) |-> lineClk);
  // R6: mono pixels are full off or full on
  assert_mono_levels_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pixTick && strb.bppLog == 2'd0) |=> (grayOut == '0 || grayOut == '1));
  // R3: nothing is emitted once disabled
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.running |=> (!pixClk && !lineClk && !acBias));
endmodule

// File: rtl/stn_gray_lcd.sv
module stn_gray_lcd
  import stn_lcd_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEn,
  input  logic               cfgWrEn,
  input  logic [WORD_W-1:0]  cfgWrData,
  input  logic               palWrEn,
  input  logic               palWrHigh,
  input  logic [WORD_W-1:0]  palWrData,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic [WORD_W-1:0]  memData,
  output logic               pixClk,
  output logic               lineClk,
  output logic               frameMark,
  output logic               acBias,
  output logic [LEVEL_W-1:0] grayOut
);
  lcdStrobe_t strb;

  stnTimingCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .memAddr(memAddr), .strb(strb)
  );

  stnPixelPath u_path (
    .clk(clk), .rstN(rstN), .palWrEn(palWrEn), .palWrHigh(palWrHigh),
    .palWrData(palWrData), .memData(memData), .strb(strb),
    .pixClk(pixClk), .lineClk(lineClk), .frameMark(frameMark),
    .acBias(acBias), .grayOut(grayOut)
  );
endmodule

// File: tb/test_stn_gray_lcd.sv
module test_stn_gray_lcd;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN, ctrlEn, cfgWrEn, palWrEn, palWrHigh;
  logic [31:0] cfgWrData, palWrData, memData;
  logic [14:0] memAddr;
  logic pixClk, lineClk, frameMark, acBias;
  logic [3:0] grayOut;

  logic [31:0] memory [64];
  assign memData = memory[memAddr[5:0]];

  stn_gray_lcd i_stn_gray_lcd (
    .clk(clk), .rstN(rstN), .ctrlEn(ctrlEn), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .palWrEn(palWrEn), .palWrHigh(palWrHigh), .palWrData(palWrData),
    .memAddr(memAddr), .memData(memData), .pixClk(pixClk), .lineClk(lineClk),
    .frameMark(frameMark), .acBias(acBias), .grayOut(grayOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: everything derived from the global pixel number.
  logic [31:0] mCfg, mPalLo, mPalHi;
  int mDiv, mP, mAc, eGray;
  bit eClk, eLine, eFrame, eAc;

  function automatic int bppOf(logic [31:0] c);
    if (c[31] && c[30]) return 4;   // R4
    if (c[30]) return 2;
    return 1;
  endfunction

  function automatic int palLevel(int i);
    if (i < 8) return int'(mPalLo[4*i +: 4]);
    return int'(mPalHi[4*(i-8) +: 4]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCfg = 0; mPalLo = 0; mPalHi = 0; mDiv = 0; mP = 0; mAc = 0;
      eClk = 0; eLine = 0; eFrame = 0; eAc = 0; eGray = 0;
    end else begin
      if (!ctrlEn) begin
        mDiv = 0; mP = 0; mAc = 0;
        eClk = 0; eLine = 0; eFrame = 0; eAc = 0; eGray = 0;
      end else begin
        eClk = 0; eLine = 0;
        if (mDiv == int'(mCfg[24:19])) begin
          int bpp, bitPos, w, idx, linePix, frameBits;
          bit lastF;
          bpp = bppOf(mCfg);
          bitPos = mP * bpp;
          w = int'(memory[bitPos / 32]);
          idx = (w >>> (bitPos % 32)) & ((1 << bpp) - 1);
          eGray = (bpp == 1) ? (idx != 0 ? 15 : 0) : palLevel(idx);
          linePix = (int'(mCfg[18:13]) + 1) * 16;
          frameBits = (int'(mCfg[12:0]) + 1) * 128;
          lastF = ((mP + 1) * bpp) == frameBits;
          eLine = ((mP % linePix) == linePix - 1) || lastF;
          eFrame = (mP / linePix) == 0;
          if (eLine) begin
            if (mAc == int'(mCfg[29:25])) begin eAc = !eAc; mAc = 0; end
            else mAc++;
          end
          mP = lastF ? 0 : mP + 1;
          eClk = 1;
          mDiv = 0;
        end else begin
          mDiv++;
        end
      end
      if (palWrEn) begin
        if (palWrHigh) mPalHi = palWrData; else mPalLo = palWrData;
      end
      if (cfgWrEn && !ctrlEn) mCfg = cfgWrData;  // R1 load, R12 ignore
    end
  end

  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      check("R2 R1", int'(pixClk), int'(eClk), "pixClk");
      check("R8", int'(lineClk), int'(eLine), "lineClk");
      check("R10", int'(frameMark), int'(eFrame), "frameMark");
      check("R11", int'(acBias), int'(eAc), "acBias");
      check(bppOf(mCfg) == 1 ? "R6" : "R7 R4", int'(grayOut), eGray, "grayOut");
      check("R5 R9", int'(memAddr), (mP * bppOf(mCfg)) / 32, "memAddr");
    end
  end

  function automatic logic [31:0] mkCfg(bit deep, bit gray, int ac, int pre, int line, int size);
    return {deep, gray, 5'(ac), 6'(pre), 6'(line), 13'(size)};
  endfunction

  task automatic writeCfg(logic [31:0] v);
    @(negedge clk); cfgWrEn = 1; cfgWrData = v;
    @(negedge clk); cfgWrEn = 0;
  endtask

  task automatic writePal(bit hi, logic [31:0] v);
    @(negedge clk); palWrEn = 1; palWrHigh = hi; palWrData = v;
    @(negedge clk); palWrEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkQuiet(string what);
    check("R3", int'(pixClk), 0, {what, " pixClk"});
    check("R3", int'(lineClk), 0, {what, " lineClk"});
    check("R3", int'(frameMark), 0, {what, " frameMark"});
    check("R3", int'(acBias), 0, {what, " acBias"});
    check("R3", int'(grayOut), 0, {what, " grayOut"});
    check("R3", int'(memAddr), 0, {what, " memAddr"});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) memory[i] = (32'(i) * 32'h9E3779B9) ^ 32'h5A5AC3C3;
    rstN = 0; ctrlEn = 0; cfgWrEn = 0; cfgWrData = 0;
    palWrEn = 0; palWrHigh = 0; palWrData = 0;
    repeat (3) @(negedge clk);
    checkQuiet("reset");
    rstN = 1;
    writePal(0, 32'h89ABCDEF);
    writePal(1, 32'h01234567);
    // 4 bpp, 16-pixel lines, 8 lines per frame, divider 2, bias group of 3 lines
    writeCfg(mkCfg(1, 1, 2, 1, 0, 3));
    @(negedge clk); ctrlEn = 1;
    idle(700);
    writePal(0, 32'h13579BDF);  // R7 live palette change
    idle(600);
    @(negedge clk); ctrlEn = 0;
    @(negedge clk);
    checkQuiet("disable");
    // 2 bpp, 32-pixel lines, 6 lines, a pixel every clock, bias every line
    writeCfg(mkCfg(0, 1, 0, 0, 1, 2));
    @(negedge clk); ctrlEn = 1;
    idle(800);
    @(negedge clk); ctrlEn = 0;
    // R4: only bit 31 set means 1 bpp; 48-pixel lines, frame ends mid-line (R9)
    writeCfg(mkCfg(1, 0, 4, 2, 2, 0));
    @(negedge clk); ctrlEn = 1;
    idle(1500);
    // R12: write while running must not change anything
    @(negedge clk); cfgWrEn = 1; cfgWrData = mkCfg(1, 1, 0, 0, 0, 1);
    @(negedge clk); cfgWrEn = 0;
    idle(600);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule